// File: doc/BRIEF.md
# Reloadable Down-Counter Timer Channel

This block is a single timer channel. Once enabled, it counts down by one on each selected tick strobe. It runs from a programmed reload value to zero, then starts again from the reload value, and it keeps going for as long as it stays enabled. Two match values, programmed in either order, mark points on the way down. When the count lands on one of them, an interrupt event is raised. A further event can be raised when the count reaches zero.

Each event inverts a toggling interrupt line. It also produces a one-cycle pulse, which a shared sticky status register outside the block can capture. Software reaches the count, reload and two match registers through a simple write port and a combinational read port. The enable, tick-source select and overflow-interrupt enable arrive as plain level inputs. The tick strobes themselves are generated elsewhere.

Top module: `dcount_timer`

## Requirements
- R1: While running (enabled, and the enable was already high on the previous cycle, and reload is nonzero), each selected strobe changes the count. A count of N>0 becomes N-1, and a count of 0 becomes the reload value. With no selected strobe, the count holds.
- R2: A match register takes effect only when its value is strictly below the reload value. Otherwise it produces no event of its own.
- R3: An event occurs each time a strobe moves the count onto a nonzero value equal to either effective match. Because the count descends, the larger match fires before the smaller one, whatever the write order. Equal matches give a single event.
- R4: When a strobe moves the count onto 0, an event occurs only if the overflow-interrupt enable is 1 or either stored match register holds 0.
- R5: Each event inverts `irq_level` and drives `evt_pulse` high for exactly the cycle after the strobe. With no event, `irq_level` holds.
- R6: Register selects are 0 = count, 1 = reload, 2 = match A, 3 = match B. Reading select 0 returns the reload value while `en` is low, and the live count while `en` is high.
- R7: Writing select 0 while enabled sets the live count to the written value on the next cycle, with no stop. This write takes priority over a strobe in the same cycle.
- R8: With reload at 0, the count stays at 0 while enabled. Writing a nonzero reload over a zero reload while enabled loads the count with that value at once. Writing a new reload over a nonzero one changes only the value used at the next wrap.
- R9: `src_ext` = 1 selects `tick_ext`, and `src_ext` = 0 selects `tick_bus`. A strobe on the unselected input has no effect.
- R10: A rising edge of `en` loads the count from reload. While `en` is low, strobes cause no count change and no event.
- R11: Reset clears the count, reload, both match registers, `irq_level` and `evt_pulse` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Channel enable |
| src_ext | input | 1 | Tick source select, 1 = external strobe |
| ovf_irq_en | input | 1 | Event on reaching zero |
| tick_ext | input | 1 | External tick strobe, one cycle wide |
| tick_bus | input | 1 | Bus-clock tick strobe, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | W | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | W | Read data, combinational |
| irq_level | output | 1 | Interrupt line, inverted on each event |
| evt_pulse | output | 1 | One-cycle event pulse |

## Verification
A wrong count shows up in the count read right after the strobe that produced it. It also makes every later event land on the wrong strobe, so the phase of `irq_level` stays off from then on. A wrong effective-match or zero-event decision appears within one strobe as a missing or extra `evt_pulse`, and the toggled line keeps that parity error for the rest of the run. A wrong enable-edge or source-select decision appears in the very next count read.

// File: rtl/dcount_timer.sv
module dcount_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         src_ext,
  input  logic         ovf_irq_en,
  input  logic         tick_ext,
  input  logic         tick_bus,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_sel,
  output logic [W-1:0] rd_data,
  output logic         irq_level,
  output logic         evt_pulse
);
  localparam logic [1:0] SEL_CNT = 2'd0;
  localparam logic [1:0] SEL_RLD = 2'd1;
  localparam logic [1:0] SEL_MA  = 2'd2;
  localparam logic [1:0] SEL_MB  = 2'd3;
  localparam logic [W-1:0] ZERO  = '0;

  logic [W-1:0] cnt, rld, ma, mb;
  logic         en_q;

  wire tick    = src_ext ? tick_ext : tick_bus;
  wire running = en && en_q && (rld != ZERO);
  wire rise    = en && !en_q;

  wire [W-1:0] eff_a = (ma < rld) ? ma : ZERO;
  wire [W-1:0] eff_b = (mb < rld) ? mb : ZERO;
  wire [W-1:0] hi    = (eff_a > eff_b) ? eff_a : eff_b;
  wire [W-1:0] lo    = (eff_a > eff_b) ? eff_b : eff_a;

  wire [W-1:0] nxt     = (cnt == ZERO) ? rld : cnt - 1'b1;
  wire         ev_hit  = (nxt != ZERO) && ((nxt == hi) || (nxt == lo));
  wire         ev_zero = (nxt == ZERO) && (ovf_irq_en || ma == ZERO || mb == ZERO);

  wire wr_cnt    = wr_en && (wr_sel == SEL_CNT) && en;
  wire start_rld = wr_en && (wr_sel == SEL_RLD) && en && (rld == ZERO) && (wr_data != ZERO);
  wire step      = running && tick && !wr_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      rld       <= '0;
      ma        <= '0;
      mb        <= '0;
      en_q      <= 1'b0;
      irq_level <= 1'b0;
      evt_pulse <= 1'b0;
    end else begin
      en_q      <= en;
      evt_pulse <= 1'b0;
      if (wr_en) begin
        case (wr_sel)
          SEL_RLD: rld <= wr_data;
          SEL_MA:  ma  <= wr_data;
          SEL_MB:  mb  <= wr_data;
          default: ;
        endcase
      end
      if (rise)           cnt <= rld;
      else if (start_rld) cnt <= wr_data;
      else if (wr_cnt)    cnt <= wr_data;
      else if (step) begin
        cnt <= nxt;
        if (ev_hit || ev_zero) begin
          irq_level <= ~irq_level;
          evt_pulse <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_CNT: rd_data = en ? cnt : rld;
      SEL_RLD: rd_data = rld;
      SEL_MA:  rd_data = ma;
      default: rd_data = mb;
    endcase
  end

  p_pulse_toggles_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> (irq_level != $past(irq_level)));
  p_quiet_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_pulse |-> (irq_level == $past(irq_level)));
  p_rise_loads_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !en_q) |=> (cnt == $past(rld)));
  p_off_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(cnt) && !evt_pulse));
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && !wr_en && cnt == ZERO) |=> (cnt == $past(rld)));
  p_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !tick && !wr_en) |=> $stable(cnt));
  p_zero_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse && cnt == ZERO) |-> $past(ovf_irq_en || ma == ZERO || mb == ZERO));
endmodule

// File: tb/dcount_timer_tb.sv
module dcount_timer_tb;
  localparam int W = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, src_ext = 1'b1, ovf_irq_en = 1'b0;
  logic tick_ext = 1'b0, tick_bus = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_sel = '0, rd_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic irq_level, evt_pulse;

  int total = 0, bad = 0;
  bit m_irq = 1'b0;

  always #4 clk = ~clk;

  dcount_timer #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .src_ext(src_ext), .ovf_irq_en(ovf_irq_en),
    .tick_ext(tick_ext), .tick_bus(tick_bus), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq_level(irq_level), .evt_pulse(evt_pulse));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input int d);
    wr_en = 1'b1; wr_sel = s; wr_data = W'(d);
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic tk(input bit ext);
    if (ext) tick_ext = 1'b1; else tick_bus = 1'b1;
    cyc();
    tick_ext = 1'b0; tick_bus = 1'b0;
  endtask

  task automatic rd_cnt(input string tag, input int exp);
    rd_sel = 2'd0; #1;
    check(rd_data == W'(exp), tag, int'(rd_data), exp);
  endtask

  task automatic setcfg(input int rl, input int a, input int b, input bit ovf);
    en = 1'b0; cyc();
    wr(2'd1, rl); wr(2'd2, a); wr(2'd3, b);
    ovf_irq_en = ovf; en = 1'b1; cyc();
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R11: reset state
    for (int s = 0; s < 4; s++) begin
      rd_sel = 2'(s); #1;
      check(rd_data == '0, "R11 reg", int'(rd_data), 0);
    end
    check(irq_level == 1'b0, "R11 irq", irq_level, 0);
    check(evt_pulse == 1'b0, "R11 pulse", evt_pulse, 0);
    rd_sel = 2'd0;

    // R1/R2/R3/R4/R5 sweep against an arithmetic model
    src_ext = 1'b1;
    for (int rl = 1; rl <= 5; rl++)
      for (int a = 0; a <= 6; a++)
        for (int b = 0; b <= 6; b++)
          for (int o = 0; o < 2; o++) begin
            int m_cnt, ea, eb;
            bit ev;
            setcfg(rl, a, b, o[0]);
            m_cnt = rl;
            rd_cnt("R10 start", rl);
            ea = (a < rl) ? a : 0;
            eb = (b < rl) ? b : 0;
            for (int k = 0; k < rl + 3; k++) begin
              tk(1'b1);
              m_cnt = (m_cnt == 0) ? rl : m_cnt - 1;
              ev = (m_cnt != 0 && (m_cnt == ea || m_cnt == eb)) ||
                   (m_cnt == 0 && (o == 1 || a == 0 || b == 0));
              if (ev) m_irq = ~m_irq;
              rd_cnt("R1 count", m_cnt);
              check(evt_pulse == ev, "R2/R3/R4 event", evt_pulse, ev);
              check(irq_level == m_irq, "R5 level", irq_level, m_irq);
            end
          end

    // R10: falling edge freezes, rising edge restarts; R6 read while disabled
    setcfg(6, 2, 4, 1'b1);
    tk(1'b1); tk(1'b1);
    rd_cnt("R10 run", 4);
    m_irq = irq_level;
    en = 1'b0; cyc();
    for (int k = 0; k < 8; k++) begin
      tk(1'b1);
      check(evt_pulse == 1'b0, "R10 no event off", evt_pulse, 0);
    end
    check(irq_level == m_irq, "R10 level held", irq_level, m_irq);
    rd_cnt("R6 disabled read", 6);
    en = 1'b1; cyc();
    rd_cnt("R10 restart", 6);
    tk(1'b1);
    rd_cnt("R10 after restart", 5);

    // R9: source select
    setcfg(6, 7, 7, 1'b0);
    src_ext = 1'b1;
    tk(1'b0);
    rd_cnt("R9 bus ignored", 6);
    src_ext = 1'b0;
    tk(1'b0);
    rd_cnt("R9 bus used", 5);
    tk(1'b1);
    rd_cnt("R9 ext ignored", 5);
    src_ext = 1'b1;

    // R7: reposition while enabled
    setcfg(20, 7, 7, 1'b0);
    tk(1'b1);
    rd_cnt("R7 pre", 19);
    wr(2'd0, 3);
    rd_cnt("R7 moved", 3);
    tk(1'b1); tk(1'b1); tk(1'b1);
    rd_cnt("R7 zero", 0);
    check(evt_pulse == 1'b0, "R4 silent zero", evt_pulse, 0);
    tk(1'b1);
    rd_cnt("R7 wrap", 20);
    // R7: count write beats a same-cycle strobe
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = W'(11); tick_ext = 1'b1;
    cyc();
    wr_en = 1'b0; tick_ext = 1'b0;
    rd_cnt("R7 write wins", 11);

    // R8: reload from zero starts at once; later reload waits for wrap
    en = 1'b0; cyc();
    wr(2'd1, 0);
    en = 1'b1; cyc();
    tk(1'b1); tk(1'b1);
    rd_cnt("R8 stalled", 0);
    wr(2'd1, 4);
    rd_cnt("R8 started", 4);
    tk(1'b1);
    rd_cnt("R8 step", 3);
    wr(2'd1, 9);
    rd_cnt("R8 no jump", 3);
    tk(1'b1); tk(1'b1); tk(1'b1);
    rd_cnt("R8 zero", 0);
    tk(1'b1);
    rd_cnt("R8 new wrap", 9);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule